// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is a presettable binary counter stage, four bits wide by default. It counts up or down on the rising edge of the clock. Every control input is sampled only at that edge. A parallel load is active-low, and so are two count enables. The first enable only allows counting. The second enable allows counting and also qualifies the carry, so it is the one used for chaining. A direction input selects increment or decrement.

A combinational, active-low terminal-count flag is decoded from the registered count. It goes low only when the chaining enable is low and the count sits at its last value for the selected direction. To build a wider synchronous counter, the flag of one stage drives the chaining enable of the next stage, with no extra gating. A synchronous active-low reset clears the count.

Top module: `updn_cnt_stage`

## Requirements
- R1: When `rst_n` is low at a rising edge, the count becomes 0. Reset takes priority over load and over counting.
- R2: When `load_n` is low at a rising edge (and `rst_n` is high), the count takes the value on `din`, whatever the enables and the direction are.
- R3: With `load_n` high, the count changes only when `cnt_en_n` and `chain_en_n` are both low at the edge. If either one is high, the count holds its value.
- R4: When counting with `dir_up` high, the count increments by one and wraps from all-ones to 0.
- R5: When counting with `dir_up` low, the count decrements by one and wraps from 0 to all-ones.
- R6: `tc_n` is low exactly when `chain_en_n` is low and the count is either all-ones with `dir_up` high, or 0 with `dir_up` low. In every other case it is high. `cnt_en_n` has no effect on `tc_n`.
- R7: Changes on the control inputs or on `din` between rising edges leave the count unchanged until the next rising edge.
- R8: Two stages, with the low stage's `tc_n` driving the high stage's `chain_en_n`, behave as one 8-bit up/down counter. This includes wrap-around and loads in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to 0 |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en_n | input | 1 | Active-low count enable (counting only) |
| chain_en_n | input | 1 | Active-low count enable that also qualifies `tc_n` |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| din | input | WIDTH | Parallel load value |
| cnt_q | output | WIDTH | Registered count |
| tc_n | output | 1 | Active-low terminal-count carry, combinational |

## Verification
A load and an enabled count can fall in the same edge. The vector table provokes this by applying a load row while both enables are low and the direction is up. The result is judged by requiring that the count equals the loaded word and not the incremented one.

The 8-bit wrap is the second such case. There, the low stage's carry and the high stage's own terminal state coincide. The bench judges it by comparing the chained count and the high stage's carry against an 8-bit reference model at every edge.

// File: rtl/updn_cnt_pkg.sv
// Package: shared operation encoding for the counter stage.
// Assumes a single clock domain; no other dependencies.
package updn_cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/updn_cnt_opdec.sv
// Module: turns the sampled control pins into one operation code.
// Assumes active-low load and enables; load outranks counting.
// Reset is handled in the register itself.
module updn_cnt_opdec
    import updn_cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    chain_en_n,
    input  logic    dir_up,
    output cnt_op_e op
);
    // Priority decode: load, then count (direction), else hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (!cnt_en_n && !chain_en_n)
            op = dir_up ? OP_INC : OP_DEC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/updn_cnt_reg.sv
// Module: the count register. It applies the decoded operation on each rising edge.
// Assumes a synchronous active-low reset; the arithmetic wraps modulo 2**WIDTH.
module updn_cnt_reg
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // State update: reset, load, step up or down, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_LOAD: q <= din;
                OP_INC:  q <= q + STEP;
                OP_DEC:  q <= q - STEP;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/updn_cnt_tcdec.sv
// Module: decodes the active-low terminal count from the registered count.
// Assumes q is a register output, so the decode is free of counting glitches.
module updn_cnt_tcdec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en_n,
    input  logic             dir_up,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_end;

    // Last value for the current direction.
    always_comb at_end = dir_up ? (q == TOP) : (q == '0);

    // The chaining enable qualifies the carry.
    always_comb tc_n = ~(at_end & ~chain_en_n);
endmodule

// File: rtl/updn_cnt_stage.sv
// Top: one cascadable up/down counter stage.
// Assumes every control is synchronous to clk. tc_n of one stage feeds
// chain_en_n of the next stage to widen the counter.
module updn_cnt_stage
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic             dir_up,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt_q,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    cnt_op_e op;

    updn_cnt_opdec u_opdec (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .dir_up     (dir_up),
        .op         (op)
    );

    updn_cnt_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .din   (din),
        .q     (cnt_q)
    );

    updn_cnt_tcdec #(.WIDTH(WIDTH)) u_tc (
        .q          (cnt_q),
        .chain_en_n (chain_en_n),
        .dir_up     (dir_up),
        .tc_n       (tc_n)
    );

    // R1: reset clears the count, even when load is requested
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0);

    // R2: a load edge copies din
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> cnt_q == $past(din));

    // R3: either enable high holds the count
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_n || chain_en_n)) |=> $stable(cnt_q));

    // R4: counting up advances by one, modulo 2**WIDTH
    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && dir_up)
            |=> cnt_q == $past(cnt_q) + ONE);

    // R5: counting down retreats by one, modulo 2**WIDTH
    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && !dir_up)
            |=> cnt_q == $past(cnt_q) - ONE);

    // R6: the carry is never low while the chaining enable is high
    p_tc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en_n |-> tc_n);

    // R6: a low carry implies the directional end value
    p_tc_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_n |-> (dir_up ? cnt_q == TOP : cnt_q == '0));
endmodule

// File: tb/test_updn_cnt_stage.sv
module test_updn_cnt_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       chain_en_n = 1'b1;
    logic       dir_up = 1'b1;
    logic [7:0] din = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi;
    logic [7:0] ref_q = 8'h00;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    updn_cnt_stage #(.WIDTH(4)) i_updn_cnt_stage (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .chain_en_n(chain_en_n), .dir_up(dir_up), .din(din[3:0]),
        .cnt_q(q_lo), .tc_n(tc_lo)
    );

    updn_cnt_stage #(.WIDTH(4)) i_updn_cnt_stage_hi (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .chain_en_n(tc_lo), .dir_up(dir_up), .din(din[7:4]),
        .cnt_q(q_hi), .tc_n(tc_hi)
    );

    // Row: {load_n, cnt_en_n, chain_en_n, dir_up, din[7:0], reps[7:0], expected[7:0]}
    localparam int NV = 19;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {4'b0001, 8'hFD, 8'd1,  8'hFD},
        {4'b1001, 8'h00, 8'd5,  8'h02},
        {4'b1000, 8'h00, 8'd4,  8'hFE},
        {4'b1101, 8'h00, 8'd3,  8'hFE},
        {4'b1011, 8'h00, 8'd3,  8'hFE},
        {4'b0001, 8'h0E, 8'd1,  8'h0E},
        {4'b1001, 8'h00, 8'd3,  8'h11},
        {4'b1000, 8'h00, 8'd2,  8'h0F},
        {4'b0001, 8'h7F, 8'd1,  8'h7F},
        {4'b1001, 8'h00, 8'd1,  8'h80},
        {4'b1000, 8'h00, 8'd1,  8'h7F},
        {4'b0001, 8'hF0, 8'd1,  8'hF0},
        {4'b1001, 8'h00, 8'd20, 8'h04},
        {4'b1000, 8'h00, 8'd6,  8'hFE},
        {4'b0001, 8'hFF, 8'd1,  8'hFF},
        {4'b1011, 8'h00, 8'd2,  8'hFF},
        {4'b1001, 8'h00, 8'd1,  8'h00},
        {4'b1100, 8'h00, 8'd2,  8'h00},
        {4'b1000, 8'h00, 8'd1,  8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected carries from the reference count and the present inputs.
    function automatic logic exp_tc(input logic [7:0] v, input int bits);
        logic term;
        if (bits == 4) term = dir_up ? (v[3:0] == 4'hF) : (v[3:0] == 4'h0);
        else           term = dir_up ? (v == 8'hFF) : (v == 8'h00);
        return !(term && !chain_en_n);
    endfunction

    // One clock: check the carries before the edge, advance the model, check the count after.
    task automatic step(input string tag);
        #1;
        chk("R6 low carry", {7'd0, tc_lo}, {7'd0, exp_tc(ref_q, 4)});
        chk("R8 chained carry", {7'd0, tc_hi}, {7'd0, exp_tc(ref_q, 8)});
        @(posedge clk);
        if (!rst_n)                            ref_q = 8'h00;
        else if (!load_n)                      ref_q = din;
        else if (!cnt_en_n && !chain_en_n)     ref_q = dir_up ? ref_q + 8'd1 : ref_q - 8'd1;
        #1;
        chk(tag, {q_hi, q_lo}, ref_q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); step("R1 reset"); @(negedge clk); step("R1 reset");
        // Table walk
        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(VEC[i][15:8]); r++) begin
                @(negedge clk);
                rst_n = 1'b1;
                {load_n, cnt_en_n, chain_en_n, dir_up} = VEC[i][27:24];
                din = VEC[i][23:16];
                step("R8 chained count");
            end
            if (!VEC[i][27])                      chk("R2 load", {q_hi, q_lo}, VEC[i][7:0]);
            else if (VEC[i][26] || VEC[i][25])    chk("R3 hold", {q_hi, q_lo}, VEC[i][7:0]);
            else if (VEC[i][24])                  chk("R4 up", {q_hi, q_lo}, VEC[i][7:0]);
            else                                  chk("R5 down", {q_hi, q_lo}, VEC[i][7:0]);
        end
        // R7: controls changing between edges do nothing until the edge
        @(negedge clk);
        load_n = 1'b0; din = 8'h55; cnt_en_n = 1'b0; chain_en_n = 1'b0; dir_up = 1'b1;
        #1 chk("R7 mid-cycle load", {q_hi, q_lo}, 8'hFF);
        load_n = 1'b1; cnt_en_n = 1'b1;
        step("R7 hold after glitch");
        chk("R7 value kept", {q_hi, q_lo}, 8'hFF);
        // R1: reset outranks a simultaneous load
        @(negedge clk);
        rst_n = 1'b0; load_n = 1'b0; din = 8'hAA;
        step("R1 reset over load");
        chk("R1 cleared", {q_hi, q_lo}, 8'h00);
        // R6: enable P does not gate the carry; T does
        @(negedge clk);
        rst_n = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1; chain_en_n = 1'b0; dir_up = 1'b0;
        #1 chk("R6 carry with P high", {7'd0, tc_lo}, 8'h00);
        chain_en_n = 1'b1;
        #1 chk("R6 carry blocked by T", {7'd0, tc_lo}, 8'h01);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule